// File: doc/BRIEF.md
# GPIO Interrupt Group Aggregator

This block turns the input levels of a 54-pin general-purpose I/O port into latched per-pin events and a small set of interrupt lines. Each pin passes through a two-flop synchroniser. It can then be armed for any mix of four conditions: a rising edge, a falling edge, a high level and a low level. When any armed condition is met, the pin's bit in its bank's event-status word sets. That bit stays set until software writes a one to it.

The pins sit in two 32-bit banks: pins 0 to 31 in bank 0, and pins 32 to 53 in bits 0 to 21 of bank 1. The three group interrupt lines are cut at pin 28 and pin 46, not at the bank boundary, so the middle group takes bits from both banks. A fourth, common line is active whenever any group line is active. A flat register port with a combinational read path gives software access to the enable words and the status words.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset, every status word and every enable word reads 0, and all four interrupt outputs are low.
- R2: A pin with its rising enable set latches its status bit when its synchronised level goes from 0 to 1. The bit reads back set by the third clock edge after the pin changes, and the interrupt outputs follow one edge later.
- R3: A pin with its falling enable set latches its status bit when its synchronised level goes from 1 to 0.
- R4: A pin with its high enable set latches while its synchronised level is 1. After a clear, the bit sets again on the following edge for as long as the level remains.
- R5: A pin with its low enable set latches while its synchronised level is 0. Once the pin is high and the bit has been cleared, it stays clear.
- R6: Writing a status word clears each bit written as 1. Bits written as 0 keep their value.
- R7: If a new event and a write-1-to-clear hit the same bit at the same edge, the bit stays set.
- R8: grp_irq_o[0] is high exactly when a latched event exists on pins 0 to 27, which is bank 0 bits 0 to 27.
- R9: grp_irq_o[1] is high exactly when a latched event exists on pins 28 to 45. That range is bank 0 bits 28 to 31 together with bank 1 bits 0 to 13.
- R10: grp_irq_o[2] is high exactly when a latched event exists on pins 46 to 53, which is bank 1 bits 14 to 21.
- R11: any_irq_o is high in exactly the cycles in which at least one grp_irq_o bit is high.
- R12: A pin with none of its four enables set never latches an event, whatever its input does.
- R13: Register address: reg_addr_i[0] selects the bank, and reg_addr_i[3:1] selects the word (0 status, 1 rising enable, 2 falling enable, 3 high enable, 4 low enable; 5 to 7 read 0). reg_rdata_o shows the addressed word in the same cycle. Bits 22 to 31 of bank 1 do not exist, cannot be written and always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 54 | Asynchronous pin levels, bit n is pin n |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 4 | Word select (bits 3:1) and bank select (bit 0) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the addressed word, combinational |
| grp_irq_o | output | 3 | Registered group interrupt lines, bit g is group g |
| any_irq_o | output | 1 | Registered common interrupt line |

## Verification
A wrong status bit shows on the register port in the same cycle it is read, and on the matching group line one edge later. The most likely faults follow from that. A misplaced group boundary lights the wrong grp_irq_o bit within four edges of a pin change. A clear that wins over a level event shows as a zero read right after the clear write. A missing synchroniser stage or edge register shifts or hides the event, and that shows as a status read that differs a few cycles after the stimulus. The bench drives pins on both sides of each group boundary and in both banks, and compares every read and every interrupt line against a model of the expected latched state.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register-select encoding for the GPIO interrupt aggregator.
// Assumes the word select sits above the bank select in the register address.
package gpio_irq_pkg;

    // Word selected by the upper address bits
    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_RISE   = 3'd1,
        SEL_FALL   = 3'd2,
        SEL_HIGH   = 3'd3,
        SEL_LOW    = 3'd4
    } reg_sel_e;

    localparam int SEL_W = 3;

endpackage

// File: rtl/gpio_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous pin levels.
// Assumes each bit is an independent level; no bus coherence is implied.
module gpio_sync #(
    parameter int W = 54
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;

    // Two register stages to settle metastability
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_event_bank.sv
// Module: one bank of event detection. Holds the four enable words, the
// previous-sample register used for edge detection, and the write-1-to-clear
// status word. Only the low VALID bits exist; the upper bits stay 0.
// Assumes smp_i is already synchronised to clk.
module gpio_event_bank
    import gpio_irq_pkg::*;
#(
    parameter int W     = 32,
    parameter int VALID = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp_i,
    input  logic         wr_i,
    input  reg_sel_e     sel_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] rise_en_o,
    output logic [W-1:0] fall_en_o,
    output logic [W-1:0] high_en_o,
    output logic [W-1:0] low_en_o,
    output logic [W-1:0] prev_o
);
    localparam logic [W-1:0] VMASK = (VALID >= W) ? {W{1'b1}}
                                                  : ((W'(1) << VALID) - W'(1));

    logic [W-1:0] event_w;
    logic [W-1:0] clr_w;

    // Any armed condition on an existing pin counts as an event
    always_comb begin
        event_w = ((rise_en_o &  smp_i & ~prev_o) |
                   (fall_en_o & ~smp_i &  prev_o) |
                   (high_en_o &  smp_i)           |
                   (low_en_o  & ~smp_i)) & VMASK;
        clr_w   = (wr_i && sel_i == SEL_STATUS) ? wdata_i : '0;
    end

    // Previous sample for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_o <= '0;
        else        prev_o <= smp_i;
    end

    // Status latch: clear by writing ones, a new event takes precedence
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_w) | event_w;
    end

    // Enable words written through the register port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en_o <= '0;
            fall_en_o <= '0;
            high_en_o <= '0;
            low_en_o  <= '0;
        end else if (wr_i) begin
            case (sel_i)
                SEL_RISE: rise_en_o <= wdata_i & VMASK;
                SEL_FALL: fall_en_o <= wdata_i & VMASK;
                SEL_HIGH: high_en_o <= wdata_i & VMASK;
                SEL_LOW:  low_en_o  <= wdata_i & VMASK;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_group_irq.sv
// Module: folds the flat pin-indexed status vector into three registered
// group lines and one common line. Group 0 takes pins below G1_FIRST,
// group 1 takes G1_FIRST up to G2_FIRST-1, and group 2 takes the rest.
// Assumes 0 < G1_FIRST < G2_FIRST < NUM_PINS <= FLAT_W.
module gpio_group_irq #(
    parameter int FLAT_W   = 64,
    parameter int NUM_PINS = 54,
    parameter int G1_FIRST = 28,
    parameter int G2_FIRST = 46
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAT_W-1:0] status_i,
    output logic [2:0]        grp_o,
    output logic              any_o
);
    logic [FLAT_W-1:0] m0, m1, m2;
    logic [2:0]        grp_next;

    // Per-pin membership masks, computed from the boundaries
    for (genvar p = 0; p < FLAT_W; p++) begin : g_mask
        assign m0[p] = (p < G1_FIRST);
        assign m1[p] = (p >= G1_FIRST) && (p < G2_FIRST);
        assign m2[p] = (p >= G2_FIRST) && (p < NUM_PINS);
    end

    // Reduce each masked slice to a request
    always_comb begin
        grp_next[0] = |(status_i & m0);
        grp_next[1] = |(status_i & m1);
        grp_next[2] = |(status_i & m2);
    end

    // Register group and common lines together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_o <= '0;
            any_o <= 1'b0;
        end else begin
            grp_o <= grp_next;
            any_o <= |grp_next;
        end
    end
endmodule

// File: rtl/gpio_irq_agg.sv
// Module: top of the GPIO interrupt aggregator. Synchronises the pins,
// runs one event bank per register bank, decodes the register port and
// drives the group and common interrupt lines.
// Assumes at least two banks; reg_addr_i[0] picks the bank.
module gpio_irq_agg
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int BANK_W   = 32,
    parameter int G1_FIRST = 28,
    parameter int G2_FIRST = 46
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                reg_wr_i,
    input  logic [3:0]          reg_addr_i,
    input  logic [BANK_W-1:0]   reg_wdata_i,
    output logic [BANK_W-1:0]   reg_rdata_o,
    output logic [2:0]          grp_irq_o,
    output logic                any_irq_o
);
    localparam int NUM_BANKS  = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int FLAT_W     = NUM_BANKS * BANK_W;
    localparam int BANK_SEL_W = $clog2(NUM_BANKS);

    logic [NUM_PINS-1:0] smp_pins;
    logic [FLAT_W-1:0]   smp_flat, prev_flat, status_flat;
    logic [FLAT_W-1:0]   rise_flat, fall_flat, high_flat, low_flat;
    logic [BANK_SEL_W-1:0] bank_sel;
    reg_sel_e            word_sel;

    assign bank_sel = reg_addr_i[BANK_SEL_W-1:0];
    assign word_sel = reg_sel_e'(reg_addr_i[BANK_SEL_W +: SEL_W]);
    assign smp_flat = FLAT_W'(smp_pins);

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_i),
        .sync_o (smp_pins)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int VALID = ((NUM_PINS - b * BANK_W) >= BANK_W)
                               ? BANK_W : (NUM_PINS - b * BANK_W);
        logic bank_wr;
        assign bank_wr = reg_wr_i && (bank_sel == BANK_SEL_W'(b));

        gpio_event_bank #(.W(BANK_W), .VALID(VALID)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp_i    (smp_flat[b*BANK_W +: BANK_W]),
            .wr_i     (bank_wr),
            .sel_i    (word_sel),
            .wdata_i  (reg_wdata_i),
            .status_o (status_flat[b*BANK_W +: BANK_W]),
            .rise_en_o(rise_flat[b*BANK_W +: BANK_W]),
            .fall_en_o(fall_flat[b*BANK_W +: BANK_W]),
            .high_en_o(high_flat[b*BANK_W +: BANK_W]),
            .low_en_o (low_flat[b*BANK_W +: BANK_W]),
            .prev_o   (prev_flat[b*BANK_W +: BANK_W])
        );
    end

    // Read mux over the addressed bank and word
    always_comb begin
        case (word_sel)
            SEL_STATUS: reg_rdata_o = status_flat[bank_sel*BANK_W +: BANK_W];
            SEL_RISE:   reg_rdata_o = rise_flat[bank_sel*BANK_W +: BANK_W];
            SEL_FALL:   reg_rdata_o = fall_flat[bank_sel*BANK_W +: BANK_W];
            SEL_HIGH:   reg_rdata_o = high_flat[bank_sel*BANK_W +: BANK_W];
            SEL_LOW:    reg_rdata_o = low_flat[bank_sel*BANK_W +: BANK_W];
            default:    reg_rdata_o = '0;
        endcase
    end

    gpio_group_irq #(
        .FLAT_W  (FLAT_W),
        .NUM_PINS(NUM_PINS),
        .G1_FIRST(G1_FIRST),
        .G2_FIRST(G2_FIRST)
    ) u_grp (
        .clk     (clk),
        .rst_n   (rst_n),
        .status_i(status_flat),
        .grp_o   (grp_irq_o),
        .any_o   (any_irq_o)
    );
endmodule

// File: rtl/gpio_irq_agg_chk.sv
// Module: assertion checker for gpio_irq_agg, attached by bind below.
// Relates the synchroniser and enable state to the status latches one edge
// later, and the common line to the group lines.
module gpio_irq_agg_chk #(
    parameter int FLAT_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FLAT_W-1:0] status,
    input logic [FLAT_W-1:0] smp,
    input logic [FLAT_W-1:0] prev,
    input logic [FLAT_W-1:0] rise,
    input logic [FLAT_W-1:0] fall,
    input logic [FLAT_W-1:0] high,
    input logic [FLAT_W-1:0] low,
    input logic [2:0]        grp,
    input logic              any_irq
);
    // R2 and R7: an armed rising edge is latched even under a clear
    p_rise_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(rise & smp & ~prev)) == $past(rise & smp & ~prev)));

    // R3: an armed falling edge is latched
    p_fall_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(fall & ~smp & prev)) == $past(fall & ~smp & prev)));

    // R4: an armed high level keeps the bit set
    p_high_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(high & smp)) == $past(high & smp)));

    // R5: an armed low level keeps the bit set
    p_low_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(low & ~smp)) == $past(low & ~smp)));

    // R12: a bit with no enable never goes from 0 to 1
    p_unarmed_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(rise | fall | high | low)) == '0));

    // R11: common line matches the group lines
    p_common_r11: assert property (@(posedge clk) disable iff (!rst_n)
        any_irq == (grp != 3'b000));
endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(.FLAT_W(FLAT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status_flat),
    .smp    (smp_flat),
    .prev   (prev_flat),
    .rise   (rise_flat),
    .fall   (fall_flat),
    .high   (high_flat),
    .low    (low_flat),
    .grp    (grp_irq_o),
    .any_irq(any_irq_o)
);

// File: tb/sim_gpio_irq_agg.sv
`timescale 1ns/1ps
module sim_gpio_irq_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [53:0] pin_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [3:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [2:0]  grp_irq_o;
    logic        any_irq_o;

    always #2.5 clk = ~clk;

    gpio_irq_agg u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .grp_irq_o(grp_irq_o), .any_irq_o(any_irq_o)
    );

    typedef struct {
        logic [31:0] data;
        logic [2:0]  grp;
        logic        any;
        string       req;
    } sb_item_t;

    sb_item_t    sbq[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [53:0] exp_st = '0;
    bit          done = 0;

    // Address helper: word select in bits 3:1, bank in bit 0
    function automatic logic [3:0] adr(int word, int bank);
        return 4'((word << 1) | bank);
    endfunction

    function automatic logic [2:0] grp_of(logic [53:0] s);
        return {|s[53:46], |s[45:28], |s[27:0]};
    endfunction

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(posedge clk); #1;
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(posedge clk); #1;
        reg_wr_i = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
    endtask

    // Driver: select a word and push the expected result
    task automatic expect_rd(logic [3:0] a, logic [31:0] d, string req, bit now = 0);
        sb_item_t it;
        if (!now) begin
            @(posedge clk); #1;
        end
        reg_addr_i = a;
        it.data = d;
        it.grp  = grp_of(exp_st);
        it.any  = |grp_of(exp_st);
        it.req  = req;
        sbq.push_back(it);
    endtask

    task automatic expect_status(string req);
        expect_rd(adr(0, 0), exp_st[31:0], req);
        expect_rd(adr(0, 1), {10'b0, exp_st[53:32]}, req);
    endtask

    // Monitor: compare at the falling edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            n_chk++;
            if (reg_rdata_o !== it.data || grp_irq_o !== it.grp || any_irq_o !== it.any) begin
                n_bad++;
                $display("FAIL %s: rdata=%h grp=%b any=%b, expected rdata=%h grp=%b any=%b",
                         it.req, reg_rdata_o, grp_irq_o, any_irq_o, it.data, it.grp, it.any);
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        expect_status("R1");
        expect_rd(adr(1, 0), 32'h0, "R1");
        expect_rd(adr(4, 1), 32'h0, "R1");

        // R2 / R8: rising edge on pin 3
        wr(adr(1, 0), 32'h0000_0008);
        pin_i[3] = 1'b1;
        wait_cyc(5);
        exp_st[3] = 1'b1;
        expect_status("R2_R8");
        // R6: zero write keeps bits
        wr(adr(0, 0), 32'h0);
        wait_cyc(2);
        expect_rd(adr(0, 0), 32'h0000_0008, "R6");
        // R6: write one clears
        wr(adr(0, 0), 32'h0000_0008);
        exp_st[3] = 1'b0;
        wait_cyc(3);
        expect_rd(adr(0, 0), 32'h0, "R6");
        pin_i[3] = 1'b0;
        wait_cyc(5);
        expect_rd(adr(0, 0), 32'h0, "R2");

        // R3 / R9: falling edge on pin 40 (bank 1 bit 8)
        pin_i[40] = 1'b1;
        wait_cyc(5);
        wr(adr(2, 1), 32'h0000_0100);
        pin_i[40] = 1'b0;
        wait_cyc(5);
        exp_st[40] = 1'b1;
        expect_status("R3_R9");
        wr(adr(0, 1), 32'h0000_0100);
        exp_st[40] = 1'b0;
        wait_cyc(3);
        expect_status("R3");

        // R9: bank 0 side of group 1, pin 30
        wr(adr(1, 0), 32'h4000_0008);
        pin_i[30] = 1'b1;
        wait_cyc(5);
        exp_st[30] = 1'b1;
        expect_status("R9");
        wr(adr(0, 0), 32'h4000_0000);
        exp_st[30] = 1'b0;
        pin_i[30] = 1'b0;
        wait_cyc(3);
        expect_status("R9");

        // R10 / R4: high level on pin 50 (bank 1 bit 18)
        wr(adr(3, 1), 32'h0004_0000);
        pin_i[50] = 1'b1;
        wait_cyc(5);
        exp_st[50] = 1'b1;
        expect_status("R10");
        // R7: clear collides with the level event
        wr(adr(0, 1), 32'h0004_0000);
        expect_rd(adr(0, 1), 32'h0004_0000, "R7", 1);
        wait_cyc(3);
        expect_rd(adr(0, 1), 32'h0004_0000, "R4");

        // R11: two groups at once
        pin_i[3] = 1'b1;
        wait_cyc(5);
        exp_st[3] = 1'b1;
        expect_status("R11");
        pin_i[3] = 1'b0;
        pin_i[50] = 1'b0;
        wait_cyc(5);
        wr(adr(0, 1), 32'h0004_0000);
        wr(adr(0, 0), 32'h0000_0008);
        exp_st = '0;
        wait_cyc(3);
        expect_status("R4_R11");

        // R5: low level on pin 0
        wr(adr(4, 0), 32'h0000_0001);
        wait_cyc(4);
        exp_st[0] = 1'b1;
        expect_status("R5");
        pin_i[0] = 1'b1;
        wait_cyc(5);
        wr(adr(0, 0), 32'h0000_0001);
        exp_st[0] = 1'b0;
        wait_cyc(3);
        expect_status("R5");
        wr(adr(4, 0), 32'h0);

        // R12: unarmed pin toggles
        pin_i[10] = 1'b1;
        wait_cyc(5);
        pin_i[10] = 1'b0;
        wait_cyc(5);
        expect_status("R12");

        // R13: register map and missing bank 1 bits
        wr(adr(1, 1), 32'hFFFF_FFFF);
        expect_rd(adr(1, 1), 32'h003F_FFFF, "R13");
        wr(adr(1, 1), 32'h0);
        expect_rd(adr(1, 0), 32'h4000_0008, "R13");
        expect_rd(adr(3, 1), 32'h0004_0000, "R13");
        expect_rd(adr(2, 1), 32'h0000_0100, "R13");
        expect_rd(4'hB, 32'h0, "R13");
        expect_status("R13");

        wait_cyc(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule